// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block is the control sequencer that a small 32-bit CPU core uses to enter exception handling. It watches the reset and non-maskable-interrupt pins, address-error and interrupt requests, and status flags from the execute and decode stages. It picks the one exception to take and then runs the entry sequence over a word-wide memory request port. At the end it hands new values for the program counter, the stack pointer (R15), the vector base and the four status-register mask bits to the register file, each through its own write strobe.

There are two kinds of reset. The level of the NMI pin when the reset pin is released selects which one runs. Each reset kind reads an initial PC and SP from its own pair of fixed low addresses. It then clears the vector base and sets the mask to all ones. Every other exception works the same way. It stores SR and then PC below the current stack pointer, reads the handler address from a vector slot at an offset from the vector base, and jumps to that address. Only an interrupt changes the mask, which takes the interrupt's level.

While the sequence runs, `busy` stays high and the core issues no new instruction.

Top module: `exc_entry_seq`

## Requirements
- R1: When `rst_pin_n` is released with `nmi_pin` high, the block reads word address 0x00000000 and then 0x00000004. The first word becomes `pc_new` and the second becomes `sp_new`.
- R2: When `rst_pin_n` is released with `nmi_pin` low, the block reads 0x00000008 and then 0x0000000C. These words are used as PC and SP in the same way as in R1.
- R3: At the end of either reset, `pc_we`, `sp_we`, `vbr_we` and `mask_we` are high in the same cycle, with `vbr_new` = 0 and `mask_new` = 4'b1111. While `rst_pin_n` is low, no memory request and no register write is made.
- R4: A non-reset exception writes the SR sampled at detection to address SP−4. It then writes the PC sampled at detection to address SP−8. Finally it sets `sp_new` = SP−8.
- R5: After the two stack writes, the block reads address VBR + 4 × vector number and writes the word it reads to `pc_new`. The vector numbers are: address error 9, interrupt 64, trap 32, slot-illegal 6, general-illegal 4.
- R6: For an interrupt, `mask_we` is high at the final step and `mask_new` is the `irq_level` sampled at detection. For the other non-reset exceptions, `mask_we` stays low.
- R7: An address error or an interrupt is taken only in a cycle where `ex_done` is high. Without `ex_done` the request has no effect: there is no memory access, no register write and `busy` stays low.
- R8: An exception is raised when `dec_valid` is high and one of these holds. `dec_undef` with `dec_in_slot` low raises general-illegal. `dec_undef` or `dec_pc_write` with `dec_in_slot` high raises slot-illegal. `dec_pc_write` outside a delay slot raises nothing.
- R9: When several sources are present in the same cycle, the order is: address error, then interrupt, then trap (`ex_trap`, which does not need `ex_done`), then the illegal-instruction kinds.
- R10: A memory request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ready` is high. The sequence moves on only after that cycle.
- R11: `busy` is high from the detection cycle through the cycle in which `pc_we` is issued. It is low in the cycle after that, unless a new exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Reset pin, active low; releasing it starts a reset sequence |
| nmi_pin | input | 1 | NMI pin level; sampled on reset release to choose the reset kind |
| addr_err_req | input | 1 | Address error request |
| irq_req | input | 1 | Accepted interrupt request |
| irq_level | input | 4 | Priority level of the interrupt |
| ex_done | input | 1 | The instruction in execute completes this cycle |
| ex_trap | input | 1 | A trap instruction is executing |
| dec_valid | input | 1 | The decode-stage flags are valid |
| dec_undef | input | 1 | The decoded opcode is undefined |
| dec_pc_write | input | 1 | The decoded instruction rewrites the PC |
| dec_in_slot | input | 1 | The decoded instruction is in a delay slot |
| cur_pc | input | 32 | PC to store on entry |
| cur_sp | input | 32 | Current R15 |
| cur_sr | input | 32 | Current status register |
| cur_vbr | input | 32 | Current vector base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | The access completes at this clock edge |
| busy | output | 1 | Entry in progress; blocks instruction issue |
| pc_we | output | 1 | PC write strobe; issues the handler fetch address |
| pc_new | output | 32 | New PC |
| sp_we | output | 1 | R15 write strobe |
| sp_new | output | 32 | New R15 |
| vbr_we | output | 1 | Vector base write strobe |
| vbr_new | output | 32 | New vector base |
| mask_we | output | 1 | Mask write strobe |
| mask_new | output | 4 | New interrupt mask |

## Verification
Every combination of the six request and decode flags is applied, each with and without `ex_done`. This sweep covers three things. It separates the priority order from each source on its own. It shows that address errors and interrupts are ignored when `ex_done` is low. It checks the delay-slot split of undefined and PC-writing opcodes, including the PC-writing case that must raise nothing.

The cases also differ in SP, PC, SR, VBR, level and memory latency. With those varied, a wrong push offset, a swapped push order, a wrong vector number or a mask value that is not a snapshot all give a wrong address or value. Both reset kinds are run with different latencies, so that the choice of vector pair and the commit values can be told apart.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        K_NONE, K_POR, K_MAN, K_ADDR, K_IRQ, K_TRAP, K_SLOT, K_GEN
    } exc_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_HOLD, S_RPC, S_RSP, S_PSR, S_PPC, S_RVEC, S_FIN
    } seq_state_e;

    localparam logic [7:0] VEC_ADDR_ERR = 8'd9;
    localparam logic [7:0] VEC_IRQ      = 8'd64;
    localparam logic [7:0] VEC_TRAP     = 8'd32;
    localparam logic [7:0] VEC_SLOT_ILL = 8'd6;
    localparam logic [7:0] VEC_GEN_ILL  = 8'd4;

    localparam logic [31:0] POR_SLOT_BASE = 32'h0000_0000;
    localparam logic [31:0] MAN_SLOT_BASE = 32'h0000_0008;

    function automatic logic [7:0] vec_num(exc_kind_e k);
        case (k)
            K_ADDR:  return VEC_ADDR_ERR;
            K_IRQ:   return VEC_IRQ;
            K_TRAP:  return VEC_TRAP;
            K_SLOT:  return VEC_SLOT_ILL;
            K_GEN:   return VEC_GEN_ILL;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/exc_src_arb.sv
module exc_src_arb
    import exc_entry_pkg::*;
(
    input  logic      addr_err_req,
    input  logic      irq_req,
    input  logic      ex_done,
    input  logic      ex_trap,
    input  logic      dec_valid,
    input  logic      dec_undef,
    input  logic      dec_pc_write,
    input  logic      dec_in_slot,
    output exc_kind_e kind
);
    logic slot_bad;
    logic gen_bad;

    always_comb begin
        // R8: delay-slot split of undefined / PC-writing opcodes
        slot_bad = dec_valid && dec_in_slot && (dec_undef || dec_pc_write);
        gen_bad  = dec_valid && !dec_in_slot && dec_undef;
        // R9 priority, R7 completion gate
        if (addr_err_req && ex_done)  kind = K_ADDR;
        else if (irq_req && ex_done)  kind = K_IRQ;
        else if (ex_trap)             kind = K_TRAP;
        else if (slot_bad)            kind = K_SLOT;
        else if (gen_bad)             kind = K_GEN;
        else                          kind = K_NONE;
    end

endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr
    import exc_entry_pkg::*;
#(
    parameter int AW = 32
) (
    input  exc_kind_e         kind,
    input  logic [AW-1:0]     vbr,
    output logic [AW-1:0]     addr
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(AW / 8);

    // R5: handler slot = base + word size * vector number
    always_comb begin
        addr = vbr + AW'(vec_num(kind)) * WORD_BYTES;
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int AW     = 32,
    parameter int MASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic              nmi_pin,
    input  logic              addr_err_req,
    input  logic              irq_req,
    input  logic [MASK_W-1:0] irq_level,
    input  logic              ex_done,
    input  logic              ex_trap,
    input  logic              dec_valid,
    input  logic              dec_undef,
    input  logic              dec_pc_write,
    input  logic              dec_in_slot,
    input  logic [AW-1:0]     cur_pc,
    input  logic [AW-1:0]     cur_sp,
    input  logic [AW-1:0]     cur_sr,
    input  logic [AW-1:0]     cur_vbr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [AW-1:0]     mem_wdata,
    input  logic [AW-1:0]     mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              pc_we,
    output logic [AW-1:0]     pc_new,
    output logic              sp_we,
    output logic [AW-1:0]     sp_new,
    output logic              vbr_we,
    output logic [AW-1:0]     vbr_new,
    output logic              mask_we,
    output logic [MASK_W-1:0] mask_new
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(AW / 8);
    localparam logic [AW-1:0] FRAME_BYTES = WORD_BYTES + WORD_BYTES;

    typedef struct packed {
        seq_state_e        st;
        exc_kind_e         kind;
        logic [AW-1:0]     sp;
        logic [AW-1:0]     pc;
        logic [AW-1:0]     sr;
        logic [AW-1:0]     vaddr;
        logic [MASK_W-1:0] lvl;
        logic [AW-1:0]     hnd;
        logic [AW-1:0]     spn;
    } seq_t;

    seq_t      seq_d, seq_q;
    exc_kind_e arb_kind;
    logic [AW-1:0] slot_addr;
    logic [AW-1:0] rst_base;
    logic      is_rst;

    exc_src_arb u_arb (
        .addr_err_req (addr_err_req),
        .irq_req      (irq_req),
        .ex_done      (ex_done),
        .ex_trap      (ex_trap),
        .dec_valid    (dec_valid),
        .dec_undef    (dec_undef),
        .dec_pc_write (dec_pc_write),
        .dec_in_slot  (dec_in_slot),
        .kind         (arb_kind)
    );

    exc_vec_addr #(.AW(AW)) u_vec (
        .kind (arb_kind),
        .vbr  (cur_vbr),
        .addr (slot_addr)
    );

    always_comb begin
        seq_d     = seq_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pc_we     = 1'b0;
        pc_new    = seq_q.hnd;
        sp_we     = 1'b0;
        sp_new    = seq_q.spn;
        vbr_we    = 1'b0;
        vbr_new   = '0;
        mask_we   = 1'b0;
        is_rst    = (seq_q.kind == K_POR) || (seq_q.kind == K_MAN);
        mask_new  = is_rst ? {MASK_W{1'b1}} : seq_q.lvl;
        rst_base  = (seq_q.kind == K_POR) ? AW'(POR_SLOT_BASE) : AW'(MAN_SLOT_BASE);

        case (seq_q.st)
            S_HOLD: begin
                // first edge with the pin released: NMI level picks kind (R1, R2)
                seq_d.kind = nmi_pin ? K_POR : K_MAN;
                seq_d.st   = S_RPC;
            end
            S_IDLE: begin
                if (arb_kind != K_NONE) begin
                    seq_d.st    = S_PSR;
                    seq_d.kind  = arb_kind;
                    seq_d.sp    = cur_sp;
                    seq_d.pc    = cur_pc;
                    seq_d.sr    = cur_sr;
                    seq_d.vaddr = slot_addr;
                    seq_d.lvl   = irq_level;
                    seq_d.spn   = cur_sp - FRAME_BYTES;
                end
            end
            S_RPC: begin
                mem_req  = 1'b1;
                mem_addr = rst_base;
                if (mem_ready) begin
                    seq_d.hnd = mem_rdata;
                    seq_d.st  = S_RSP;
                end
            end
            S_RSP: begin
                mem_req  = 1'b1;
                mem_addr = rst_base + WORD_BYTES;
                if (mem_ready) begin
                    seq_d.spn = mem_rdata;
                    seq_d.st  = S_FIN;
                end
            end
            S_PSR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = seq_q.sp - WORD_BYTES;
                mem_wdata = seq_q.sr;
                if (mem_ready) seq_d.st = S_PPC;
            end
            S_PPC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = seq_q.sp - FRAME_BYTES;
                mem_wdata = seq_q.pc;
                if (mem_ready) seq_d.st = S_RVEC;
            end
            S_RVEC: begin
                mem_req  = 1'b1;
                mem_addr = seq_q.vaddr;
                if (mem_ready) begin
                    seq_d.hnd = mem_rdata;
                    seq_d.st  = S_FIN;
                end
            end
            S_FIN: begin
                pc_we    = 1'b1;
                sp_we    = 1'b1;
                vbr_we   = is_rst;
                mask_we  = is_rst || (seq_q.kind == K_IRQ);
                seq_d.st = S_IDLE;
            end
            default: seq_d.st = S_IDLE;
        endcase

        busy = (seq_q.st != S_IDLE) || (arb_kind != K_NONE);
    end

    always_ff @(posedge clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            seq_q      <= '0;
            seq_q.st   <= S_HOLD;
            seq_q.kind <= K_NONE;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R10: a pending access keeps its request steady
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

    // R11: handler fetch is issued while busy
    a_r11_busy_at_fetch: assert property (@(posedge clk) disable iff (!rst_pin_n)
        pc_we |-> busy);

    // R11: busy only drops right after the fetch address was issued
    a_r11_busy_release: assert property (@(posedge clk) disable iff (!rst_pin_n)
        $fell(busy) |-> $past(pc_we));

    // R3: reset commit writes all four targets together
    a_r3_reset_commit: assert property (@(posedge clk) disable iff (!rst_pin_n)
        vbr_we |-> (pc_we && sp_we && mask_we && (vbr_new == '0)
                    && (mask_new == {MASK_W{1'b1}})));

    // R6: outside resets, only an interrupt touches the mask
    a_r6_mask_irq_only: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mask_we && !vbr_we) |-> (seq_q.kind == K_IRQ));

    // R4: stack writes never coincide with the final register update
    a_r4_push_before_commit: assert property (@(posedge clk) disable iff (!rst_pin_n)
        (mem_req && mem_we) |-> (busy && !pc_we && !sp_we));

endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

    logic        clk = 1'b0;
    logic        rst_pin_n = 1'b0;
    logic        nmi_pin = 1'b1;
    logic        addr_err_req = 1'b0, irq_req = 1'b0, ex_done = 1'b0, ex_trap = 1'b0;
    logic [3:0]  irq_level = 4'd0;
    logic        dec_valid = 1'b0, dec_undef = 1'b0, dec_pc_write = 1'b0, dec_in_slot = 1'b0;
    logic [31:0] cur_pc = '0, cur_sp = '0, cur_sr = '0, cur_vbr = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        busy, pc_we, sp_we, vbr_we, mask_we;
    logic [31:0] pc_new, sp_new, vbr_new;
    logic [3:0]  mask_new;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    exc_entry_seq u_exc_entry_seq (
        .clk(clk), .rst_pin_n(rst_pin_n), .nmi_pin(nmi_pin),
        .addr_err_req(addr_err_req), .irq_req(irq_req), .irq_level(irq_level),
        .ex_done(ex_done), .ex_trap(ex_trap), .dec_valid(dec_valid),
        .dec_undef(dec_undef), .dec_pc_write(dec_pc_write), .dec_in_slot(dec_in_slot),
        .cur_pc(cur_pc), .cur_sp(cur_sp), .cur_sr(cur_sr), .cur_vbr(cur_vbr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .pc_we(pc_we), .pc_new(pc_new), .sp_we(sp_we), .sp_new(sp_new),
        .vbr_we(vbr_we), .vbr_new(vbr_new), .mask_we(mask_we), .mask_new(mask_new)
    );

    function automatic logic [31:0] memword(input logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'hA5A5_5A5A;
    endfunction

    task automatic check(input string req, input logic ok, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory model and observation, all at the falling edge
    int          lat = 0;
    int          wcnt = 0;
    logic        waiting = 1'b0;
    logic [31:0] w_addr, w_data;
    logic        w_we;
    int          r10_bad = 0;
    int          nlog = 0;
    logic        log_we [0:7];
    logic [31:0] log_addr [0:7];
    logic [31:0] log_wd [0:7];
    logic        fin_seen = 1'b0;
    logic [31:0] f_pc, f_sp, f_vbr;
    logic        f_sp_we, f_vbr_we, f_mask_we;
    logic [3:0]  f_mask;

    always @(negedge clk) begin
        if (mem_req && waiting &&
            (mem_addr != w_addr || mem_we != w_we || (mem_we && mem_wdata != w_data)))
            r10_bad++;
        if (!mem_req) begin
            mem_ready = 1'b0; wcnt = 0; waiting = 1'b0;
        end else if (wcnt >= lat) begin
            mem_ready = 1'b1;
            mem_rdata = memword(mem_addr);
            if (nlog < 8) begin
                log_we[nlog] = mem_we; log_addr[nlog] = mem_addr; log_wd[nlog] = mem_wdata;
            end
            nlog++;
            wcnt = 0; waiting = 1'b0;
        end else begin
            mem_ready = 1'b0; wcnt++; waiting = 1'b1;
            w_addr = mem_addr; w_we = mem_we; w_data = mem_wdata;
        end
        if (pc_we) begin
            fin_seen = 1'b1;
            f_pc = pc_new; f_sp = sp_new; f_vbr = vbr_new;
            f_sp_we = sp_we; f_vbr_we = vbr_we; f_mask_we = mask_we; f_mask = mask_new;
        end
    end

    // waits for the final step; returns whether busy held throughout
    task automatic wait_fin(output logic busy_ok);
        busy_ok = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #1;
            if (fin_seen) break;
            if (!busy) busy_ok = 1'b0;
        end
    endtask

    task automatic do_reset(input logic nmi, input int l);
        logic [31:0] base;
        logic        bok;
        base = nmi ? 32'h0 : 32'h8;
        lat = l;
        @(negedge clk);
        rst_pin_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R3 hold quiet", !mem_req && !pc_we && !sp_we && !vbr_we && !mask_we,
              {27'd0, mem_req, pc_we, sp_we, vbr_we, mask_we}, 32'd0);
        nmi_pin = nmi;
        nlog = 0; fin_seen = 1'b0;
        @(negedge clk);
        rst_pin_n = 1'b1;
        wait_fin(bok);
        check(nmi ? "R1 fin" : "R2 fin", fin_seen, {31'd0, fin_seen}, 32'd1);
        check(nmi ? "R1 count" : "R2 count", nlog == 2, nlog, 2);
        check(nmi ? "R1 pc slot" : "R2 pc slot", !log_we[0] && log_addr[0] == base,
              log_addr[0], base);
        check(nmi ? "R1 sp slot" : "R2 sp slot", !log_we[1] && log_addr[1] == base + 4,
              log_addr[1], base + 4);
        check(nmi ? "R1 pc value" : "R2 pc value", f_pc == memword(base), f_pc, memword(base));
        check(nmi ? "R1 sp value" : "R2 sp value", f_sp_we && f_sp == memword(base + 4),
              f_sp, memword(base + 4));
        check("R3 vbr clear", f_vbr_we && f_vbr == 32'd0, f_vbr, 32'd0);
        check("R3 mask ones", f_mask_we && f_mask == 4'hF, {28'd0, f_mask}, 32'hF);
        @(negedge clk); #1;
        check("R11 busy drop after reset", !busy, {31'd0, busy}, 32'd0);
    endtask

    task automatic run_case(input int m);
        logic ae, irq, trp, und, pcw, slt, exd;
        logic [7:0]  vec;
        logic        any, bok;
        logic [31:0] sp, pc, sr, vbr, vaddr;
        logic [3:0]  lvl;
        string       tag;
        ae = m[0]; irq = m[1]; trp = m[2]; und = m[3]; pcw = m[4]; slt = m[5]; exd = m[6];
        any = 1'b1;
        if (ae && exd)                vec = 8'd9;
        else if (irq && exd)          vec = 8'd64;
        else if (trp)                 vec = 8'd32;
        else if (slt && (und || pcw)) vec = 8'd6;
        else if (!slt && und)         vec = 8'd4;
        else begin vec = 8'd0; any = 1'b0; end
        tag = ($countones({ae && exd, irq && exd, trp, und || pcw}) > 1) ? "R9" :
              (vec == 8'd6 || vec == 8'd4) ? "R8" : "R5";
        sp  = 32'h0000_1000 + 32'(m) * 32'h40;
        pc  = 32'h2000_0000 + 32'(m) * 2;
        sr  = 32'h0000_00F0 ^ 32'(m);
        vbr = 32'h0400_0000 + 32'(m) * 32'h100;
        lvl = 4'(m * 7 + 3);
        vaddr = vbr + 32'(vec) * 4;
        lat = m % 3;
        nlog = 0; fin_seen = 1'b0;
        @(negedge clk);
        cur_sp = sp; cur_pc = pc; cur_sr = sr; cur_vbr = vbr; irq_level = lvl;
        addr_err_req = ae; irq_req = irq; ex_trap = trp; dec_valid = 1'b1;
        dec_undef = und; dec_pc_write = pcw; dec_in_slot = slt; ex_done = exd;
        #1;
        check("R11 busy at detection", busy == any, {31'd0, busy}, {31'd0, any});
        @(negedge clk);
        addr_err_req = 1'b0; irq_req = 1'b0; ex_trap = 1'b0; dec_valid = 1'b0;
        dec_undef = 1'b0; dec_pc_write = 1'b0; dec_in_slot = 1'b0; ex_done = 1'b0;
        irq_level = 4'd0; cur_sp = ~sp; cur_pc = ~pc; cur_sr = ~sr; cur_vbr = 32'h0;
        if (!any) begin
            repeat (6) @(negedge clk);
            #1;
            check((pcw && !slt) ? "R8 pc write outside slot ignored" : "R7 ignored",
                  nlog == 0 && !fin_seen && !busy,
                  {nlog[29:0], fin_seen, busy}, 32'd0);
        end else begin
            wait_fin(bok);
            check("R11 busy held", bok, {31'd0, bok}, 32'd1);
            check("R4 access count", nlog == 3, nlog, 3);
            check("R4 sr push", log_we[0] && log_addr[0] == sp - 4 && log_wd[0] == sr,
                  log_addr[0], sp - 4);
            check("R4 pc push", log_we[1] && log_addr[1] == sp - 8 && log_wd[1] == pc,
                  log_addr[1], sp - 8);
            check({tag, " vector slot"}, !log_we[2] && log_addr[2] == vaddr,
                  log_addr[2], vaddr);
            check("R5 handler pc", f_pc == memword(vaddr), f_pc, memword(vaddr));
            check("R4 sp new", f_sp_we && f_sp == sp - 8, f_sp, sp - 8);
            check("R3 vbr untouched", !f_vbr_we, {31'd0, f_vbr_we}, 32'd0);
            if (vec == 8'd64)
                check("R6 irq mask", f_mask_we && f_mask == lvl,
                      {27'd0, f_mask_we, f_mask}, {27'd1, lvl});
            else
                check("R6 mask kept", !f_mask_we, {31'd0, f_mask_we}, 32'd0);
            @(negedge clk); #1;
            check("R11 busy released", !busy, {31'd0, busy}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        do_reset(1'b1, 0);
        do_reset(1'b0, 2);
        for (int m = 0; m < 128; m++) run_case(m);
        do_reset(1'b0, 1);
        do_reset(1'b1, 2);
        check("R10 request steady while waiting", r10_bad == 0, r10_bad, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule